// File: doc/BRIEF.md
# Windowed Register Access Bridge

This block gives a 32-bit host bus access to a small file of 16-bit control registers. The register file is modelled as slow, so the host never addresses it directly. It goes through two 32-bit windows instead. The host places a value in the data window. It then writes a command word into the command window. The command word names the target register and carries a flag that selects write or read. Each accepted command starts one internal access. The access takes a fixed, parameterised number of cycles, and a busy status bit stays set for all of them. When a read finishes, the register contents are loaded into the data window.

Three consecutive registers of the file together form a 48-bit station address, which is brought out on a port. The first of the three registers supplies the most significant 16 bits. Within that register, the high byte is octet 0. A command written while an access is still in progress is dropped, and a sticky error bit records the loss. Host software is expected to poll busy, or simply wait out the latency, before it issues the next access.

Top module: `reg_window_bridge`

## Requirements
- R1: After reset the data window, command window and status window all read 0, the station address output is 0, and every internal register reads 0.
- R2: A host write to the command window (offset 1) with bit 15 set and busy clear starts an internal write. When the access finishes, register `cmd[7:0]` holds the data-window value.
- R3: A host write to the command window with bit 15 clear and busy clear starts an internal read. When it finishes, the data window (offset 0) reads `{16'h0, register}`.
- R4: Status bit 0 (busy) at offset 2 rises at the clock edge that accepts a command and stays high for exactly ACC_LAT cycles.
- R5: A command-window write made while busy is set starts no access and leaves every register unchanged. It also sets status bit 1 (error).
- R6: The error bit stays set until the host writes offset 2 with bit 1 set. A status write with bit 1 clear leaves it unchanged.
- R7: A data-window write made while busy is set is ignored. This applies both to the value being written to a register and to the result of a read.
- R8: `station_addr_o` is `{reg[STA_BASE], reg[STA_BASE+1], reg[STA_BASE+2]}`, so octet 0 appears on bits 47:40.
- R9: A register address at or above NUM_REGS selects no register. A write to it changes nothing, and a read of it returns 0.
- R10: The data window keeps only the low 16 bits of a host write and always reads back with bits 31:16 at zero.
- R11: A host read returns data with `rvalid_o` high in the cycle after the request. The command window reads back the last accepted command word in full, and offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access strobe, one cycle per access |
| we_i | input | 1 | Host write when 1, read when 0 |
| addr_i | input | 2 | Window select: 0 data, 1 command, 2 status, 3 unused |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| station_addr_o | output | 48 | 48-bit station address taken from three registers |

## Verification
A wrong busy count shows up at the ports right away. If busy ends too early, a status read at the final busy cycle returns 0. It also lets a second command through, which then fails to set the error bit. A latched command with the wrong flag or address is only visible one access later: the register read back holds the wrong value, or the station address changes when it should not. A corrupted data window appears in the very next data-window read. That read is scoreboarded against an expected value worked out from the host's own sequence of writes.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam int HOST_W  = 32;
  localparam int REG_W   = 16;
  localparam int RA_W    = 8;
  localparam int WR_BIT  = 15;
  localparam int BUSY_BIT = 0;
  localparam int ERR_BIT  = 1;

  typedef enum logic [1:0] {
    WIN_DATA = 2'd0,
    WIN_CMD  = 2'd1,
    WIN_STAT = 2'd2,
    WIN_NONE = 2'd3
  } win_e;
endpackage

// File: rtl/rwb_seq.sv
module rwb_seq #(
  parameter int ACC_LAT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(ACC_LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (issue_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(ACC_LAT - 1);
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rwb_regfile.sv
module rwb_regfile
  import rwb_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int STA_BASE  = 4,
  parameter int STA_WORDS = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [RA_W-1:0]            addr_i,
  input  logic [REG_W-1:0]           wdata_i,
  output logic [REG_W-1:0]           rdata_o,
  output logic [STA_WORDS*REG_W-1:0] station_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [REG_W-1:0] mem_q [NUM_REGS];
  logic             hit;
  logic [IDX_W-1:0] idx;

  assign hit = (32'(addr_i) < NUM_REGS);
  assign idx = IDX_W'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i && hit) begin
      mem_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = hit ? mem_q[idx] : '0;

  // first station register lands in the most significant word
  for (genvar g = 0; g < STA_WORDS; g++) begin : g_sta
    assign station_o[(STA_WORDS-1-g)*REG_W +: REG_W] = mem_q[STA_BASE+g];
  end
endmodule

// File: rtl/rwb_host_if.sv
module rwb_host_if
  import rwb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [HOST_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic              issue_o,
  output logic              acc_wr_o,
  output logic [RA_W-1:0]   acc_addr_o,
  output logic [REG_W-1:0]  acc_data_o,
  output logic              err_o
);
  logic [REG_W-1:0]  data_q;
  logic [HOST_W-1:0] cmd_q;
  logic              err_q;
  logic [HOST_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              wr_data, wr_cmd, wr_stat, reject;
  logic [HOST_W-1:0] rd_mux;

  assign wr_data = req_i && we_i && (addr_i == WIN_DATA);
  assign wr_cmd  = req_i && we_i && (addr_i == WIN_CMD);
  assign wr_stat = req_i && we_i && (addr_i == WIN_STAT);
  assign issue_o = wr_cmd && !busy_i;
  assign reject  = wr_cmd && busy_i;

  assign acc_wr_o   = cmd_q[WR_BIT];
  assign acc_addr_o = cmd_q[RA_W-1:0];
  assign acc_data_o = data_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cmd_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (done_i && !cmd_q[WR_BIT]) data_q <= rd_data_i;
      else if (wr_data && !busy_i)  data_q <= wdata_i[REG_W-1:0];
      if (issue_o) cmd_q <= wdata_i;
      if (reject) err_q <= 1'b1;
      else if (wr_stat && wdata_i[ERR_BIT]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (win_e'(addr_i))
      WIN_DATA: rd_mux = {{(HOST_W-REG_W){1'b0}}, data_q};
      WIN_CMD:  rd_mux = cmd_q;
      WIN_STAT: begin
        rd_mux[BUSY_BIT] = busy_i;
        rd_mux[ERR_BIT]  = err_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/reg_window_bridge.sv
module reg_window_bridge
  import rwb_pkg::*;
#(
  parameter int ACC_LAT  = 8,
  parameter int NUM_REGS = 16,
  parameter int STA_BASE = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic [47:0] station_addr_o
);
  localparam int STA_WORDS = 48 / REG_W;

  logic             busy, done, issue, err;
  logic             acc_wr;
  logic [RA_W-1:0]  acc_addr;
  logic [REG_W-1:0] acc_data, rf_rdata;

  rwb_host_if u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .busy_i     (busy),
    .done_i     (done),
    .rd_data_i  (rf_rdata),
    .issue_o    (issue),
    .acc_wr_o   (acc_wr),
    .acc_addr_o (acc_addr),
    .acc_data_o (acc_data),
    .err_o      (err)
  );

  rwb_seq #(.ACC_LAT(ACC_LAT)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .busy_o  (busy),
    .done_o  (done)
  );

  rwb_regfile #(
    .NUM_REGS  (NUM_REGS),
    .STA_BASE  (STA_BASE),
    .STA_WORDS (STA_WORDS)
  ) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (done && acc_wr),
    .addr_i    (acc_addr),
    .wdata_i   (acc_data),
    .rdata_o   (rf_rdata),
    .station_o (station_addr_o)
  );
endmodule

// File: rtl/rwb_chk.sv
module rwb_chk
  import rwb_pkg::*;
#(
  parameter int ACC_LAT = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic        err_bit_i,
  input logic        rvalid_o,
  input logic [31:0] rdata_o,
  input logic [47:0] station_addr_o,
  input logic        busy_i,
  input logic        err_i
);
  localparam int BC_W = $clog2(ACC_LAT + 1) + 1;

  logic [BC_W-1:0] bcnt_q;
  logic            cmd_wr;

  assign cmd_wr = req_i && we_i && (addr_i == WIN_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bcnt_q <= '0;
    else if (busy_i)  bcnt_q <= bcnt_q + 1'b1;
    else              bcnt_q <= '0;
  end

  p_issue_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !busy_i) |=> busy_i);

  p_busy_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (32'(bcnt_q) < ACC_LAT));

  p_busy_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && 32'(bcnt_q) < ACC_LAT - 1) |=> busy_i);

  p_reject_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> err_i);

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(req_i && we_i && addr_i == WIN_STAT && err_bit_i)) |=> err_i);

  p_station_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(station_addr_o));

  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_no_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  p_data_upper_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == WIN_DATA) |=> (rdata_o[31:16] == 16'h0));
endmodule

bind reg_window_bridge rwb_chk #(.ACC_LAT(ACC_LAT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_i          (req_i),
  .we_i           (we_i),
  .addr_i         (addr_i),
  .err_bit_i      (wdata_i[1]),
  .rvalid_o       (rvalid_o),
  .rdata_o        (rdata_o),
  .station_addr_o (station_addr_o),
  .busy_i         (busy),
  .err_i          (err)
);

// File: tb/reg_window_bridge_bench.sv
`timescale 1ns/1ps
module reg_window_bridge_bench;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [47:0] station;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  reg_window_bridge #(.ACC_LAT(LAT), .NUM_REGS(16), .STA_BASE(4)) u_reg_window_bridge (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .station_addr_o(station)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at the next one
  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] ra, input logic [15:0] v);
    bus_wr(2'd0, {16'h0, v});
    bus_wr(2'd1, 32'h8000 | 32'(ra));
    repeat (LAT) @(negedge clk);
  endtask

  task automatic reg_read(input logic [7:0] ra, input logic [15:0] exp, input string tag);
    bus_wr(2'd1, 32'(ra));
    repeat (LAT) @(negedge clk);
    bus_rd(2'd0, {16'h0, exp}, tag);
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rvalid", 64'(rdata), 64'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata === e, t, 64'(rdata), 64'(e));
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(station === 48'h0, "R1 station reset", 64'(station), 64'h0);
    bus_rd(2'd0, 32'h0, "R1 data window reset");
    bus_rd(2'd1, 32'h0, "R1 command window reset");
    bus_rd(2'd2, 32'h0, "R1 status reset");
    reg_read(8'd4, 16'h0, "R1 register reset");

    // R10 upper half dropped
    bus_wr(2'd0, 32'hABCD_1234);
    bus_rd(2'd0, 32'h0000_1234, "R10 data window upper bits");

    // R4 busy window
    bus_wr(2'd1, 32'h0000_8003);
    bus_rd(2'd2, 32'h1, "R4 busy after issue");
    repeat (LAT - 2) @(negedge clk);
    bus_rd(2'd2, 32'h1, "R4 busy in last cycle");
    bus_rd(2'd2, 32'h0, "R4 busy cleared");

    // R2 / R3 write then read back
    reg_read(8'd3, 16'h1234, "R2 write reaches register");
    reg_write(8'd7, 16'hBEEF);
    reg_read(8'd7, 16'hBEEF, "R3 read second register");
    reg_read(8'd3, 16'h1234, "R3 first register kept");

    // R5 command while busy
    bus_wr(2'd0, 32'h5555);
    bus_wr(2'd1, 32'h8003);
    bus_wr(2'd1, 32'h8007);
    repeat (LAT) @(negedge clk);
    bus_rd(2'd2, 32'h2, "R5 error set by rejected command");
    reg_read(8'd7, 16'hBEEF, "R5 rejected write had no effect");
    reg_read(8'd3, 16'h5555, "R5 accepted write completed");

    // R6 sticky error
    bus_wr(2'd2, 32'h0);
    bus_rd(2'd2, 32'h2, "R6 error held on plain status write");
    bus_wr(2'd2, 32'h2);
    bus_rd(2'd2, 32'h0, "R6 error cleared");

    // R7 data window writes while busy
    bus_wr(2'd1, 32'h0003);
    bus_wr(2'd0, 32'h9999);
    repeat (LAT) @(negedge clk);
    bus_rd(2'd0, 32'h5555, "R7 read result not overwritten");
    bus_wr(2'd0, 32'h1111);
    bus_wr(2'd1, 32'h8007);
    bus_wr(2'd0, 32'h2222);
    repeat (LAT) @(negedge clk);
    reg_read(8'd7, 16'h1111, "R7 write value not overwritten");

    // R8 station address
    reg_write(8'd4, 16'hACDE);
    reg_write(8'd5, 16'h4800);
    reg_write(8'd6, 16'h0080);
    check(station === 48'hACDE_4800_0080, "R8 station address", 64'(station), 64'hACDE_4800_0080);
    check(station[47:40] === 8'hAC, "R8 octet 0 position", 64'(station[47:40]), 64'hAC);

    // R9 out of range
    reg_write(8'h20, 16'h7777);
    reg_read(8'h20, 16'h0, "R9 out of range reads zero");
    reg_read(8'h00, 16'h0, "R9 no alias into register 0");
    check(station === 48'hACDE_4800_0080, "R9 station untouched", 64'(station), 64'hACDE_4800_0080);

    // R11 command window readback, unused offset, rvalid timing
    bus_wr(2'd0, 32'h0);
    bus_wr(2'd1, 32'h5A5A_8006);
    repeat (LAT) @(negedge clk);
    bus_rd(2'd1, 32'h5A5A_8006, "R11 command window readback");
    bus_rd(2'd3, 32'h0, "R11 unused offset reads zero");
    check(rvalid === 1'b1, "R11 rvalid after request", 64'(rvalid), 64'h1);
    @(negedge clk);
    check(rvalid === 1'b0, "R11 rvalid single cycle", 64'(rvalid), 64'h0);
    reg_read(8'd6, 16'h0, "R11 write via full command word");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", 64'(exp_q.size()), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule